// File: doc/BRIEF.md
# Redundant Serial Configuration Command Decoder

This block takes configuration commands for a front-end readout chip over two independent serial ports, left and right. Two controllers can reach the chip without sharing any wiring. Each port delivers one bit per bit strobe. A frame opens with a single 1 bit, followed by a 10-bit header (chip address, then function code). Depending on the function, a 68-bit data field, a 2-bit event address, or no further input follows. The block owns the chip's configuration state: three 64-channel masks (trigger, data, calibration), a 14-bit DAC word, and a 2-bit mode word.

The mode word picks which port is in charge and sets a deaf flag. Either port may rewrite the mode word at any time. Every other command is acted on only when it arrives on the port currently in charge. Readback copies a register image into a separate shift register, so the stored register is not disturbed, and returns the image over 68 strobes. A calibrate command raises a strobe for a fixed number of core clock cycles. An event-read command only forwards its 2-bit buffer address to the event readout logic.

All logic runs on one core clock. Each port's bit strobe is assumed already synchronous to that clock, with one strobe per bit.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: An idle port ignores 0 bits. A 1 bit starts a frame: 5 address bits then 5 function bits, both MSB first. Function codes: 01 trigger mask write, 02 data mask write, 03 calibration mask write, 04 DAC write, 05 mode write, 08 calibrate, 09 event read, 11 to 15 read back the same five registers in the same order (hex). Any other code ends the frame after the header.
- R2: A frame is acted on only if its address equals `chip_addr` or is 5'h1F (broadcast). A frame with another address still consumes its data field and changes nothing.
- R3: A mask write takes 68 data bits, first bit = B67. Channels 0–15, 16–31, 32–47 and 48–63 come from B0–B15, B17–B32, B34–B49 and B51–B66. B16, B33, B50 and B67 always read back as 1, whatever was written to them.
- R4: A DAC write keeps the last 14 of its 68 data bits. The first 7 of those bits, in arrival order, form `thr_dac` (MSB first: range bit then 6-bit code). The last 7 form `cal_dac` the same way.
- R5: A mode write keeps the last two data bits. The second-to-last bit sets `sel_right` (1 = right port in charge) and the last bit sets `deaf`. A mode write from either port is accepted, whichever port is in charge.
- R6: The port not in charge ignores every command except mode write. Its readback output stays 0 and it produces no event pulse.
- R7: A readback frame drives the first image bit on the port output right after the last header bit. Each of the next 68 strobes advances it by one bit, MSB first. Mask images are as in R3. The DAC image is its 14 bits in R4 order, then 54 zeros. The mode image is `sel_right`, `deaf`, then 66 zeros. Readback leaves the register unchanged.
- R8: A calibrate command raises `cal_strobe` one cycle after the last header bit, and keeps it high for exactly CAL_LEN (512) core cycles. A new calibrate command while the strobe is high restarts the full count.
- R9: An event read takes 2 address bits, MSB first. One cycle after the second bit, `evt_valid` pulses for one cycle with that address on `evt_addr`.
- R10: After reset all channel masks are 0, both DAC fields are 0, the left port is in charge, `deaf` is 0, and `cal_strobe` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_addr | input | 5 | Strapped chip address |
| l_bit_en | input | 1 | Left port bit strobe |
| l_bit_in | input | 1 | Left port serial command data |
| l_bit_out | output | 1 | Left port serial readback data |
| r_bit_en | input | 1 | Right port bit strobe |
| r_bit_in | input | 1 | Right port serial command data |
| r_bit_out | output | 1 | Right port serial readback data |
| trig_mask | output | 64 | Per-channel trigger enable |
| data_mask | output | 64 | Per-channel data enable |
| cal_mask | output | 64 | Per-channel calibration injection enable |
| thr_dac | output | 7 | Threshold DAC word (range bit, 6-bit code) |
| cal_dac | output | 7 | Calibration DAC word (range bit, 6-bit code) |
| deaf | output | 1 | Ignore inputs from neighbouring chips |
| sel_right | output | 1 | 1 when the right port is in charge |
| cal_strobe | output | 1 | Calibration step, CAL_LEN cycles long |
| evt_valid | output | 1 | One-cycle event read request |
| evt_addr | output | 2 | Event buffer row for the read |

## Verification
A frame counter that slips by one bit shows up on the very next write: the outputs take a pattern shifted by one channel, and a later frame is misread, often as an unknown function. A wrong gating decision at header time shows within two cycles of the frame's last bit, as a mask that changed when it should not have, or a missing `evt_valid`. A readback register loaded from the wrong source, or shifted off by one, shows in the first few returned bits. The marker positions expose a corrupted mask image. A calibration counter error shows only at the strobe's far end, so the bench counts the full width of every strobe.

// File: rtl/cfgdec_pkg.sv
// Shared constants, state type and mask packing for the configuration
// command decoder. Assumes 64 channels in four groups of sixteen.
package cfgdec_pkg;
    localparam int FRAME_W = 68;
    localparam int HDR_W   = 10;
    localparam int ADDR_W  = 5;
    localparam int FUNC_W  = HDR_W - ADDR_W;
    localparam int N_CH    = 64;
    localparam int GROUP   = 16;
    localparam int N_GRP   = N_CH / GROUP;
    localparam int DAC_W   = 14;
    localparam int DHALF_W = DAC_W / 2;
    localparam int MODE_W  = 2;
    localparam int EADDR_W = 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [ADDR_W-1:0] BCAST = '1;

    localparam logic [FUNC_W-1:0] F_WR_TRG  = 5'h01;
    localparam logic [FUNC_W-1:0] F_WR_DAT  = 5'h02;
    localparam logic [FUNC_W-1:0] F_WR_CAL  = 5'h03;
    localparam logic [FUNC_W-1:0] F_WR_DAC  = 5'h04;
    localparam logic [FUNC_W-1:0] F_WR_MODE = 5'h05;
    localparam logic [FUNC_W-1:0] F_CAL     = 5'h08;
    localparam logic [FUNC_W-1:0] F_EVT     = 5'h09;
    localparam logic [FUNC_W-1:0] F_RD_TRG  = 5'h11;
    localparam logic [FUNC_W-1:0] F_RD_DAT  = 5'h12;
    localparam logic [FUNC_W-1:0] F_RD_CAL  = 5'h13;
    localparam logic [FUNC_W-1:0] F_RD_DAC  = 5'h14;
    localparam logic [FUNC_W-1:0] F_RD_MODE = 5'h15;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DAT, ST_RD} st_t;

    // Insert a forced 1 after each group of channels.
    function automatic logic [FRAME_W-1:0] pack_mask(input logic [N_CH-1:0] ch);
        logic [FRAME_W-1:0] f;
        f = '0;
        for (int g = 0; g < N_GRP; g++) begin
            f[g*(GROUP+1) +: GROUP] = ch[g*GROUP +: GROUP];
            f[g*(GROUP+1) + GROUP]  = 1'b1;
        end
        return f;
    endfunction

    // Drop the marker positions and keep the channel bits.
    function automatic logic [N_CH-1:0] unpack_mask(input logic [FRAME_W-1:0] f);
        logic [N_CH-1:0] ch;
        for (int g = 0; g < N_GRP; g++)
            ch[g*GROUP +: GROUP] = f[g*(GROUP+1) +: GROUP];
        return ch;
    endfunction
endpackage

// File: rtl/cfg_port_fsm.sv
// One serial command port: finds the start bit, shifts the header, collects
// the data field or streams a readback image. Writes leave as a one-cycle
// pulse carrying function and data. Assumes one bit per bit_en strobe.
// Acceptance (address match, port in charge) is decided at header end.
module cfg_port_fsm
    import cfgdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic [ADDR_W-1:0]   strap,
    input  logic                active,
    input  logic [FRAME_W-1:0]  rd_img,
    output logic [FUNC_W-1:0]   rd_func,
    output logic                bit_out,
    output logic                wr_valid,
    output logic [FUNC_W-1:0]   wr_func,
    output logic [FRAME_W-1:0]  wr_data,
    output logic                cal_go,
    output logic                evt_go,
    output logic [EADDR_W-1:0]  evt_addr
);
    st_t                st;
    logic [HDR_W-1:0]   hdr;
    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] ro;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last;
    logic [FUNC_W-1:0]  func_q;
    logic               take;

    logic [HDR_W-1:0]   hdr_n;
    logic [ADDR_W-1:0]  addr_n;
    logic [FUNC_W-1:0]  func_n;
    logic               ok_n;
    logic               is_wr;
    logic               is_rd;
    logic [FRAME_W-1:0] sh_n;

    // Header decode on the bit being shifted in now.
    always_comb begin
        hdr_n   = {hdr[HDR_W-2:0], bit_in};
        addr_n  = hdr_n[HDR_W-1 -: ADDR_W];
        func_n  = hdr_n[FUNC_W-1:0];
        ok_n    = ((addr_n == strap) || (addr_n == BCAST)) &&
                  (active || (func_n == F_WR_MODE));
        is_wr   = func_n inside {F_WR_TRG, F_WR_DAT, F_WR_CAL, F_WR_DAC, F_WR_MODE};
        is_rd   = func_n inside {F_RD_TRG, F_RD_DAT, F_RD_CAL, F_RD_DAC, F_RD_MODE};
        sh_n    = {sh[FRAME_W-2:0], bit_in};
        rd_func = func_n;
        bit_out = (st == ST_RD) ? ro[FRAME_W-1] : 1'b0;
    end

    // Frame state machine with registered command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; hdr <= '0; sh <= '0; ro <= '0; cnt <= '0;
            last <= '0; func_q <= '0; take <= 1'b0;
            wr_valid <= 1'b0; wr_func <= '0; wr_data <= '0;
            cal_go <= 1'b0; evt_go <= 1'b0; evt_addr <= '0;
        end else begin
            wr_valid <= 1'b0;
            cal_go   <= 1'b0;
            evt_go   <= 1'b0;
            if (bit_en) begin
                case (st)
                    ST_IDLE: if (bit_in) begin
                        st  <= ST_HDR;
                        cnt <= '0;
                    end
                    ST_HDR: begin
                        hdr <= hdr_n;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(HDR_W-1)) begin
                            cnt    <= '0;
                            func_q <= func_n;
                            take   <= ok_n;
                            if (is_wr) begin
                                st <= ST_DAT; last <= CNT_W'(FRAME_W-1);
                            end else if (func_n == F_EVT) begin
                                st <= ST_DAT; last <= CNT_W'(EADDR_W-1);
                            end else if (is_rd && ok_n) begin
                                st <= ST_RD; ro <= rd_img;
                            end else begin
                                st     <= ST_IDLE;
                                cal_go <= ok_n && (func_n == F_CAL);
                            end
                        end
                    end
                    ST_DAT: begin
                        sh  <= sh_n;
                        cnt <= cnt + 1'b1;
                        if (cnt == last) begin
                            st <= ST_IDLE;
                            if (take && func_q == F_EVT) begin
                                evt_go   <= 1'b1;
                                evt_addr <= sh_n[EADDR_W-1:0];
                            end else if (take) begin
                                wr_valid <= 1'b1;
                                wr_func  <= func_q;
                                wr_data  <= sh_n;
                            end
                        end
                    end
                    default: begin
                        ro  <= {ro[FRAME_W-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(FRAME_W-1)) begin
                            st <= ST_IDLE; cnt <= '0;
                        end
                    end
                endcase
            end
        end
    end

    // Readback is entered only from a completed header.
    assert_rd_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD && $past(st) != ST_RD) |-> ($past(st) == ST_HDR && $past(bit_en)));

    // Event request is a single-cycle pulse.
    assert_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_go |=> !evt_go);
endmodule

// File: rtl/cfg_regs.sv
// Configuration storage: three channel masks, DAC word and mode word,
// written from the two ports' write pulses. Assumes the ports already
// gated acceptance; on a same-cycle clash the left port wins.
module cfg_regs
    import cfgdec_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     wr_valid,
    input  logic [1:0][FUNC_W-1:0]         wr_func,
    input  logic [1:0][FRAME_W-1:0]        wr_data,
    output logic [N_CH-1:0]                trig_q,
    output logic [N_CH-1:0]                data_q,
    output logic [N_CH-1:0]                cal_q,
    output logic [DAC_W-1:0]               dac_q,
    output logic [MODE_W-1:0]              mode_q
);
    // Apply accepted writes, right first so left overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0; data_q <= '0; cal_q <= '0; dac_q <= '0; mode_q <= '0;
        end else begin
            for (int p = 1; p >= 0; p--) begin
                if (wr_valid[p]) begin
                    case (wr_func[p])
                        F_WR_TRG:  trig_q <= unpack_mask(wr_data[p]);
                        F_WR_DAT:  data_q <= unpack_mask(wr_data[p]);
                        F_WR_CAL:  cal_q  <= unpack_mask(wr_data[p]);
                        F_WR_DAC:  dac_q  <= wr_data[p][DAC_W-1:0];
                        F_WR_MODE: mode_q <= wr_data[p][MODE_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Trigger mask only moves after a trigger mask write pulse.
    assert_trg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q != $past(trig_q)) |->
        $past((wr_valid[0] && wr_func[0] == F_WR_TRG) || (wr_valid[1] && wr_func[1] == F_WR_TRG)));

    // Mode word only moves after a mode write pulse from either port.
    assert_mode_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |->
        $past((wr_valid[0] && wr_func[0] == F_WR_MODE) || (wr_valid[1] && wr_func[1] == F_WR_MODE)));
endmodule

// File: rtl/cal_timer.sv
// Calibration step timer: a go pulse raises the strobe on the next cycle
// for CAL_LEN cycles; a go during the strobe restarts the full length.
module cal_timer #(
    parameter int CAL_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic strobe
);
    localparam int TW = $clog2(CAL_LEN);
    logic [TW-1:0] left_q;

    // Count down the remaining strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0; left_q <= '0;
        end else if (go) begin
            strobe <= 1'b1; left_q <= TW'(CAL_LEN-1);
        end else if (strobe) begin
            if (left_q == '0) strobe <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    // Strobe starts only from a calibrate request.
    assert_cal_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(go));
endmodule

// File: rtl/cfg_cmd_decoder.sv
// Top: two redundant serial command ports sharing one set of configuration
// registers. The mode word picks the port in charge; each port builds its
// readback image from the stored registers. Single core clock assumed.
module cfg_cmd_decoder
    import cfgdec_pkg::*;
#(
    parameter int CAL_LEN = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   chip_addr,
    input  logic                l_bit_en,
    input  logic                l_bit_in,
    output logic                l_bit_out,
    input  logic                r_bit_en,
    input  logic                r_bit_in,
    output logic                r_bit_out,
    output logic [N_CH-1:0]     trig_mask,
    output logic [N_CH-1:0]     data_mask,
    output logic [N_CH-1:0]     cal_mask,
    output logic [DHALF_W-1:0]  thr_dac,
    output logic [DHALF_W-1:0]  cal_dac,
    output logic                deaf,
    output logic                sel_right,
    output logic                cal_strobe,
    output logic                evt_valid,
    output logic [EADDR_W-1:0]  evt_addr
);
    logic [1:0]                  en, din, dout, act, wv, cg, eg;
    logic [1:0][FUNC_W-1:0]      rfunc, wf;
    logic [1:0][FRAME_W-1:0]     img, wd;
    logic [1:0][EADDR_W-1:0]     ea;
    logic [DAC_W-1:0]            dac_q;
    logic [MODE_W-1:0]           mode_q;

    assign en  = {r_bit_en, l_bit_en};
    assign din = {r_bit_in, l_bit_in};
    assign act = {sel_right, !sel_right};
    assign l_bit_out = dout[0];
    assign r_bit_out = dout[1];

    for (genvar p = 0; p < 2; p++) begin : g_port
        // Select the readback image for the header now being decoded.
        always_comb begin
            case (rfunc[p])
                F_RD_TRG:  img[p] = pack_mask(trig_mask);
                F_RD_DAT:  img[p] = pack_mask(data_mask);
                F_RD_CAL:  img[p] = pack_mask(cal_mask);
                F_RD_DAC:  img[p] = {dac_q, {(FRAME_W-DAC_W){1'b0}}};
                F_RD_MODE: img[p] = {mode_q, {(FRAME_W-MODE_W){1'b0}}};
                default:   img[p] = '0;
            endcase
        end

        cfg_port_fsm u_port (
            .clk(clk), .rst_n(rst_n), .bit_en(en[p]), .bit_in(din[p]),
            .strap(chip_addr), .active(act[p]), .rd_img(img[p]),
            .rd_func(rfunc[p]), .bit_out(dout[p]), .wr_valid(wv[p]),
            .wr_func(wf[p]), .wr_data(wd[p]), .cal_go(cg[p]),
            .evt_go(eg[p]), .evt_addr(ea[p])
        );
    end

    cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_func(wf), .wr_data(wd),
        .trig_q(trig_mask), .data_q(data_mask), .cal_q(cal_mask),
        .dac_q(dac_q), .mode_q(mode_q)
    );

    cal_timer #(.CAL_LEN(CAL_LEN)) u_cal (
        .clk(clk), .rst_n(rst_n), .go(|cg), .strobe(cal_strobe)
    );

    assign thr_dac   = dac_q[DAC_W-1 -: DHALF_W];
    assign cal_dac   = dac_q[DHALF_W-1:0];
    assign sel_right = mode_q[1];
    assign deaf      = mode_q[0];
    assign evt_valid = |eg;
    assign evt_addr  = eg[0] ? ea[0] : ea[1];

    // A port not in charge never raises a non-mode write.
    assert_inactive_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wv[1] && wf[1] != F_WR_MODE) |-> $past(sel_right, 1) || $past(sel_right, 2) || sel_right);
endmodule

// File: tb/cfg_cmd_decoder_bench.sv
module cfg_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] chip_addr = 5'h06;
    logic l_bit_en = 0, l_bit_in = 0, r_bit_en = 0, r_bit_in = 0;
    logic l_bit_out, r_bit_out;
    logic [63:0] trig_mask, data_mask, cal_mask;
    logic [6:0] thr_dac, cal_dac;
    logic deaf, sel_right, cal_strobe, evt_valid;
    logic [1:0] evt_addr;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_cmd_decoder u_cfg_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr),
        .l_bit_en(l_bit_en), .l_bit_in(l_bit_in), .l_bit_out(l_bit_out),
        .r_bit_en(r_bit_en), .r_bit_in(r_bit_in), .r_bit_out(r_bit_out),
        .trig_mask(trig_mask), .data_mask(data_mask), .cal_mask(cal_mask),
        .thr_dac(thr_dac), .cal_dac(cal_dac), .deaf(deaf), .sel_right(sel_right),
        .cal_strobe(cal_strobe), .evt_valid(evt_valid), .evt_addr(evt_addr)
    );

    task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [67:0] img_of(input logic [63:0] ch);
        logic [67:0] f;
        for (int g = 0; g < 4; g++) begin
            f[g*17 +: 16] = ch[g*16 +: 16];
            f[g*17 + 16]  = 1'b1;
        end
        return f;
    endfunction

    // One strobe on the chosen port (0 left, 1 right); returns at a negedge.
    task automatic strobe(input bit port, input logic b);
        @(negedge clk);
        if (port) begin r_bit_en = 1; r_bit_in = b; end
        else      begin l_bit_en = 1; l_bit_in = b; end
        @(negedge clk);
        l_bit_en = 0; r_bit_en = 0; l_bit_in = 0; r_bit_in = 0;
    endtask

    task automatic header(input bit port, input logic [4:0] a, input logic [4:0] f);
        strobe(port, 1'b1);
        for (int i = 4; i >= 0; i--) strobe(port, a[i]);
        for (int i = 4; i >= 0; i--) strobe(port, f[i]);
    endtask

    task automatic write68(input bit port, input logic [4:0] a, input logic [4:0] f,
                           input logic [67:0] d);
        header(port, a, f);
        for (int i = 67; i >= 0; i--) strobe(port, d[i]);
        repeat (3) @(negedge clk);
    endtask

    task automatic read68(input bit port, input logic [4:0] a, input logic [4:0] f,
                          output logic [67:0] v);
        header(port, a, f);
        for (int i = 67; i >= 0; i--) begin
            v[i] = port ? r_bit_out : l_bit_out;
            strobe(port, 1'b0);
        end
    endtask

    task automatic t_reset();
        logic [67:0] v;
        check("R10 trig", {4'b0, trig_mask}, 68'h0);
        check("R10 data", {4'b0, data_mask}, 68'h0);
        check("R10 cal", {4'b0, cal_mask}, 68'h0);
        check("R10 dac", {54'b0, thr_dac, cal_dac}, 68'h0);
        check("R10 mode/strobes", {64'b0, deaf, sel_right, cal_strobe, evt_valid}, 68'h0);
        read68(0, 5'h06, 5'h11, v);
        check("R10 R3 reset markers", v, img_of(64'h0));
    endtask

    task automatic t_masks();
        logic [63:0] a = 64'hA5A5_0F0F_1234_8001;
        logic [63:0] b = 64'h8000_FFFF_0001_7FFE;
        logic [63:0] c = 64'h0123_4567_89AB_CDEF;
        logic [67:0] v;
        repeat (5) strobe(0, 1'b0); // R1 idle zeros
        write68(0, 5'h06, 5'h01, img_of(a) & ~68'h8_0004_0002_0001_0000);
        check("R3 R1 trig write", {4'b0, trig_mask}, {4'b0, a});
        write68(0, 5'h06, 5'h02, img_of(b));
        check("R3 data write", {4'b0, data_mask}, {4'b0, b});
        write68(0, 5'h06, 5'h03, img_of(c));
        check("R3 cal write", {4'b0, cal_mask}, {4'b0, c});
        read68(0, 5'h06, 5'h11, v);
        check("R7 R3 trig readback markers", v, img_of(a));
        read68(0, 5'h06, 5'h11, v);
        check("R7 repeat readback", v, img_of(a));
        check("R7 trig unchanged", {4'b0, trig_mask}, {4'b0, a});
        read68(0, 5'h06, 5'h13, v);
        check("R7 cal readback", v, img_of(c));
    endtask

    task automatic t_dac_addr();
        logic [67:0] v;
        write68(0, 5'h06, 5'h04, {54'h2A_5555_1234_CC, 7'h5A, 7'h23});
        check("R4 thr", {61'b0, thr_dac}, 68'h5A);
        check("R4 cal", {61'b0, cal_dac}, 68'h23);
        read68(0, 5'h06, 5'h14, v);
        check("R7 dac image", v, {7'h5A, 7'h23, 54'b0});
        write68(0, 5'h07, 5'h04, {54'b0, 7'h11, 7'h22});
        check("R2 wrong addr ignored", {54'b0, thr_dac, cal_dac}, {54'b0, 7'h5A, 7'h23});
        write68(0, 5'h1F, 5'h04, {54'b0, 7'h11, 7'h22});
        check("R2 broadcast", {54'b0, thr_dac, cal_dac}, {54'b0, 7'h11, 7'h22});
        header(0, 5'h06, 5'h1E); // R1 unknown function ends after header
        write68(0, 5'h06, 5'h02, 68'h0);
        check("R1 resync after unknown", {4'b0, data_mask}, 68'h0);
    endtask

    task automatic t_mode();
        logic [67:0] v;
        write68(1, 5'h06, 5'h05, {66'h3_FFFF_FFFF_FFFF_FFFC, 2'b10});
        check("R5 right takes charge", {66'b0, sel_right, deaf}, 68'h2);
        write68(0, 5'h06, 5'h01, img_of(64'hFFFF));
        check("R6 left ignored", {4'b0, trig_mask}, {4'b0, 64'hA5A5_0F0F_1234_8001});
        read68(0, 5'h06, 5'h11, v);
        check("R6 inactive readback zero", v, 68'h0);
        write68(1, 5'h06, 5'h01, img_of(64'hFFFF));
        check("R6 right applies", {4'b0, trig_mask}, 68'hFFFF);
        read68(1, 5'h06, 5'h15, v);
        check("R7 mode image", v, {2'b10, 66'b0});
        write68(0, 5'h06, 5'h05, {66'b0, 2'b01});
        check("R5 left mode write while inactive", {66'b0, sel_right, deaf}, 68'h1);
    endtask

    task automatic t_evt();
        header(0, 5'h06, 5'h09);
        strobe(0, 1'b1);
        check("R9 no early pulse", {67'b0, evt_valid}, 68'h0);
        strobe(0, 1'b0);
        check("R9 pulse", {65'b0, evt_valid, evt_addr}, 68'h6);
        @(negedge clk);
        check("R9 one cycle", {67'b0, evt_valid}, 68'h0);
        header(1, 5'h06, 5'h09);
        strobe(1, 1'b1);
        strobe(1, 1'b1);
        check("R6 inactive event", {67'b0, evt_valid}, 68'h0);
    endtask

    task automatic t_cal();
        int n;
        header(0, 5'h06, 5'h08);
        check("R8 not yet high", {67'b0, cal_strobe}, 68'h0);
        n = 0;
        @(negedge clk);
        while (cal_strobe && n < 2000) begin n++; @(negedge clk); end
        check("R8 width", 68'(n), 68'd512);
        header(0, 5'h06, 5'h08);
        repeat (100) @(negedge clk);
        header(0, 5'h06, 5'h08);
        check("R8 still high at retrigger", {67'b0, cal_strobe}, 68'h1);
        n = 0;
        @(negedge clk);
        while (cal_strobe && n < 2000) begin n++; @(negedge clk); end
        check("R8 retrigger restarts", 68'(n), 68'd512);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_dac_addr();
        t_mode();
        t_evt();
        t_cal();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule